// File: doc/BRIEF.md
# Random Memory Trace Generator

This block stands in for a processor core on one memory port. After a start pulse it issues a pseudo-random series of loads, stores and fences to a small pool of word addresses that every core in the system shares, so that cores contend for the same locations. The series is fixed by a 32-bit seed. Each request carries a tag. Responses may come back in any order and are matched to their requests by tag.

Every store writes a value that no other store in the system writes. The value is built from the core id and a per-core store count. Each issued request, each response and each completed fence is emitted on a trace port as a record stamped with a free-running cycle count. An external consistency checker can then read the whole run. Unknown response tags and requests left outstanding too long raise sticky error flags. A done flag rises once the configured number of operations has been carried out and every response has returned.

Top module: `mtrace_gen`

## Requirements
- R1: While reset is asserted, `req_valid_o`, `trc_valid_o`, `done_o`, `err_unknown_o` and `err_timeout_o` are all 0.
- R2: The operation generator is a 32-bit Galois LFSR stepping right with mask 0x80200003 when bit 0 is set. It is loaded with `seed_i` at an accepted start, with a zero seed replaced by 1, and it advances once per operation carried out. State bits [1:0] select the operation: 0 is a fence, 1 is a load, 2 and 3 are stores. Bits [2 +: log2(POOL_N)] select the pool index, and the address is POOL_BASE + 4 × index.
- R3: The request tag is 0 at the first request after a start and rises by one per issued request. Fences consume no tag.
- R4: `req_op_o` is 0 for a load and 1 for a store. Store data is {`core_id_i`, store count}, where the count is 1 for the first store after a start and rises by one per store. Load requests carry data 0.
- R5: At most MAX_OUT requests are outstanding. A request whose tag shares its low log2(MAX_OUT) bits with an outstanding tag is held back.
- R6: A fence issues no request. It waits until no request is outstanding and then emits a trace record of kind 3 that carries the next unused tag, with address 0 and data 0.
- R7: Each event produces one trace record in the cycle after it. The kinds are 0 for a load request, 1 for a store request, 2 for a response and 3 for a fence. The record carries the core id and the cycle count of the event cycle, where the count is 0 at the first clock edge after reset. Request records hold the tag, address and data. Response records hold the returned tag and data, with address 0.
- R8: In a cycle with `rsp_valid_i` high, no request is offered and no fence completes.
- R9: `done_o` rises after OPS_TOTAL operations have been carried out and no request is outstanding. It stays high, with no requests offered, until the next start.
- R10: A response whose tag matches no outstanding request sets `err_unknown_o`. It stays set until the next accepted start.
- R11: A request outstanding for TIMEOUT cycles sets `err_timeout_o`. It stays set until the next accepted start.
- R12: Two runs with the same seed and core id produce identical request streams.
- R13: A start pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seed_i | input | 32 | Seed loaded at start |
| core_id_i | input | CORE_W | Core identity, held steady |
| start_i | input | 1 | Begins a run when not running |
| req_valid_o | output | 1 | Request offered |
| req_ready_i | input | 1 | Port accepts the request |
| req_op_o | output | 1 | 0 load, 1 store |
| req_addr_o | output | ADDR_W | Word address |
| req_data_o | output | DATA_W | Store value |
| req_tag_o | output | TAG_W | Request tag |
| rsp_valid_i | input | 1 | Response present |
| rsp_tag_i | input | TAG_W | Tag of the answered request |
| rsp_data_i | input | DATA_W | Loaded value, 0 for stores |
| trc_valid_o | output | 1 | Trace record valid |
| trc_core_o | output | CORE_W | Core id in record |
| trc_kind_o | output | 2 | Record kind |
| trc_tag_o | output | TAG_W | Record tag |
| trc_addr_o | output | ADDR_W | Record address |
| trc_data_o | output | DATA_W | Record value |
| trc_time_o | output | TS_W | Cycle count of the event |
| done_o | output | 1 | Run complete |
| err_unknown_o | output | 1 | Response with unmatched tag seen |
| err_timeout_o | output | 1 | Request outstanding too long |

## Verification
The assertions assume that the port answers only tags it has accepted, so that the low tag bits pick a free slot on issue. They also assume that start is not raised in the same cycle as an accepted request. The bench keeps a list of the requests it has accepted and answers only from that list. It picks either the oldest or the newest entry, so completions come out of order. It withholds responses only in the timeout scenario. It sends a foreign tag only after a run has finished, when the unknown-tag flag is meant to be set. Start pulses last one cycle and are raised only at a clock's falling edge.

// File: rtl/mtrace_pkg.sv
package mtrace_pkg;

  localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

  typedef enum logic [1:0] {
    TK_LOAD  = 2'd0,
    TK_STORE = 2'd1,
    TK_RESP  = 2'd2,
    TK_FENCE = 2'd3
  } trc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction

endpackage

// File: rtl/mtrace_lfsr.sv
module mtrace_lfsr
  import mtrace_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] seed_i,
  input  logic        adv_i,
  output logic [31:0] state_o
);

  logic [31:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (load_i)     st_d = (seed_i == 32'd0) ? 32'd1 : seed_i;
    else if (adv_i) st_d = lfsr_next(st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 32'd1;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R2: a stepped maximal-length register never sits on a fixed point
  p_lfsr_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (state_o != $past(state_o)));

endmodule

// File: rtl/mtrace_slots.sv
module mtrace_slots #(
  parameter int unsigned N       = 4,
  parameter int unsigned TAG_W   = 8,
  parameter int unsigned TIMEOUT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             issue_i,
  input  logic [TAG_W-1:0] issue_tag_i,
  input  logic             rsp_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  output logic             free_o,
  output logic             any_busy_o,
  output logic             known_o,
  output logic             timeout_o
);

  localparam int unsigned SLOT_W = $clog2(N);
  localparam int unsigned AGE_W  = $clog2(TIMEOUT + 1);

  logic [SLOT_W-1:0] iss_slot;
  logic [N-1:0]      busy_vec, hit_vec, exp_vec;

  assign iss_slot = issue_tag_i[SLOT_W-1:0];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic             vld_q, vld_d;
    logic [TAG_W-1:0] tag_q;
    logic [AGE_W-1:0] age_q, age_d;
    logic             set_s, hit_s;

    assign set_s = issue_i && (iss_slot == SLOT_W'(g));
    assign hit_s = vld_q && (tag_q == rsp_tag_i);

    always_comb begin
      vld_d = vld_q;
      age_d = age_q;
      if (clear_i) begin
        vld_d = 1'b0;
        age_d = '0;
      end else if (set_s) begin
        vld_d = 1'b1;
        age_d = '0;
      end else if (rsp_i && hit_s) begin
        vld_d = 1'b0;
      end else if (vld_q && (age_q != AGE_W'(TIMEOUT))) begin
        age_d = age_q + AGE_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        age_q <= '0;
        tag_q <= '0;
      end else begin
        vld_q <= vld_d;
        age_q <= age_d;
        if (set_s) tag_q <= issue_tag_i;
      end
    end

    assign busy_vec[g] = vld_q;
    assign hit_vec[g]  = hit_s;
    assign exp_vec[g]  = vld_q && (age_q == AGE_W'(TIMEOUT));
  end

  assign free_o     = !busy_vec[iss_slot];
  assign any_busy_o = |busy_vec;
  assign known_o    = |hit_vec;
  assign timeout_o  = |exp_vec;

  // R5: the caller only issues into an empty slot
  p_issue_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> !busy_vec[iss_slot]);

  // R5: outstanding tags differ in their slot bits, so at most one matches
  p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/mtrace_gen.sv
module mtrace_gen
  import mtrace_pkg::*;
#(
  parameter int unsigned CORE_W    = 4,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_W     = 8,
  parameter int unsigned MAX_OUT   = 4,
  parameter int unsigned POOL_N    = 4,
  parameter int unsigned POOL_BASE = 32'h100,
  parameter int unsigned OPS_TOTAL = 40,
  parameter int unsigned TIMEOUT   = 32,
  parameter int unsigned TS_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       seed_i,
  input  logic [CORE_W-1:0] core_id_i,
  input  logic              start_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic [TAG_W-1:0]  req_tag_o,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              trc_valid_o,
  output logic [CORE_W-1:0] trc_core_o,
  output logic [1:0]        trc_kind_o,
  output logic [TAG_W-1:0]  trc_tag_o,
  output logic [ADDR_W-1:0] trc_addr_o,
  output logic [DATA_W-1:0] trc_data_o,
  output logic [TS_W-1:0]   trc_time_o,
  output logic              done_o,
  output logic              err_unknown_o,
  output logic              err_timeout_o
);

  localparam int unsigned PIDX_W = $clog2(POOL_N);
  localparam int unsigned SC_W   = DATA_W - CORE_W;
  localparam int unsigned OPS_W  = $clog2(OPS_TOTAL + 1);

  run_state_e        st_q, st_d;
  logic [31:0]       lfsr_s;
  logic [OPS_W-1:0]  ops_q, ops_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [SC_W-1:0]   sc_q, sc_d;
  logic [TS_W-1:0]   cyc_q;
  logic              eu_q, eu_d, et_q, et_d;

  logic              tv_q, tv_d;
  logic [CORE_W-1:0] tc_q, tc_d;
  trc_kind_e         tk_q, tk_d;
  logic [TAG_W-1:0]  tt_q, tt_d;
  logic [ADDR_W-1:0] ta_q, ta_d;
  logic [DATA_W-1:0] td_q, td_d;
  logic [TS_W-1:0]   ts_q, ts_d;

  logic              is_fence, is_store, more_ops, running;
  logic              slot_free, any_busy, rsp_known, age_hit;
  logic              fire, fence_go, op_adv, start_go;
  logic [PIDX_W-1:0] pidx;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic              unused_lfsr;

  mtrace_lfsr u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start_go),
    .seed_i  (seed_i),
    .adv_i   (op_adv),
    .state_o (lfsr_s)
  );

  mtrace_slots #(.N(MAX_OUT), .TAG_W(TAG_W), .TIMEOUT(TIMEOUT)) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (start_go),
    .issue_i     (fire),
    .issue_tag_i (tag_q),
    .rsp_i       (rsp_valid_i),
    .rsp_tag_i   (rsp_tag_i),
    .free_o      (slot_free),
    .any_busy_o  (any_busy),
    .known_o     (rsp_known),
    .timeout_o   (age_hit)
  );

  // operation decode
  assign unused_lfsr = ^lfsr_s[31:2+PIDX_W];
  assign is_fence    = (lfsr_s[1:0] == 2'b00);
  assign is_store    = lfsr_s[1];
  assign pidx        = lfsr_s[2 +: PIDX_W];
  assign op_addr     = ADDR_W'(POOL_BASE) + ADDR_W'({pidx, 2'b00});
  assign op_data     = is_store ? {core_id_i, sc_q} : '0;

  assign running  = (st_q == ST_RUN);
  assign more_ops = (ops_q != OPS_W'(OPS_TOTAL));
  assign start_go = start_i && !running;
  assign req_valid_o = running && more_ops && !is_fence && slot_free && !rsp_valid_i;
  assign fire     = req_valid_o && req_ready_i;
  assign fence_go = running && more_ops && is_fence && !any_busy && !rsp_valid_i;
  assign op_adv   = fire || fence_go;

  always_comb begin
    st_d  = st_q;
    ops_d = ops_q;
    tag_d = tag_q;
    sc_d  = sc_q;
    eu_d  = eu_q;
    et_d  = et_q;
    if (start_go) begin
      st_d  = ST_RUN;
      ops_d = '0;
      tag_d = '0;
      sc_d  = SC_W'(1);
      eu_d  = 1'b0;
      et_d  = 1'b0;
    end else begin
      if (running && !more_ops && !any_busy) st_d = ST_DONE;
      if (op_adv)             ops_d = ops_q + OPS_W'(1);
      if (fire)               tag_d = tag_q + TAG_W'(1);
      if (fire && is_store)   sc_d  = sc_q + SC_W'(1);
      if (rsp_valid_i && !rsp_known) eu_d = 1'b1;
      if (age_hit)            et_d = 1'b1;
    end
  end

  // trace record: responses take the single record slot first
  always_comb begin
    tv_d = rsp_valid_i || fire || fence_go;
    tc_d = core_id_i;
    ts_d = cyc_q;
    tk_d = TK_RESP;
    tt_d = rsp_tag_i;
    ta_d = '0;
    td_d = rsp_data_i;
    if (!rsp_valid_i) begin
      tt_d = tag_q;
      if (fire) begin
        tk_d = is_store ? TK_STORE : TK_LOAD;
        ta_d = op_addr;
        td_d = op_data;
      end else begin
        tk_d = TK_FENCE;
        td_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ops_q <= '0;
      tag_q <= '0;
      sc_q  <= SC_W'(1);
      cyc_q <= '0;
      eu_q  <= 1'b0;
      et_q  <= 1'b0;
      tv_q  <= 1'b0;
      tc_q  <= '0;
      tk_q  <= TK_LOAD;
      tt_q  <= '0;
      ta_q  <= '0;
      td_q  <= '0;
      ts_q  <= '0;
    end else begin
      st_q  <= st_d;
      ops_q <= ops_d;
      tag_q <= tag_d;
      sc_q  <= sc_d;
      cyc_q <= cyc_q + TS_W'(1);
      eu_q  <= eu_d;
      et_q  <= et_d;
      tv_q  <= tv_d;
      if (tv_d) begin
        tc_q <= tc_d;
        tk_q <= tk_d;
        tt_q <= tt_d;
        ta_q <= ta_d;
        td_q <= td_d;
        ts_q <= ts_d;
      end
    end
  end

  assign req_op_o      = is_store;
  assign req_addr_o    = op_addr;
  assign req_data_o    = op_data;
  assign req_tag_o     = tag_q;
  assign trc_valid_o   = tv_q;
  assign trc_core_o    = tc_q;
  assign trc_kind_o    = tk_q;
  assign trc_tag_o     = tt_q;
  assign trc_addr_o    = ta_q;
  assign trc_data_o    = td_q;
  assign trc_time_o    = ts_q;
  assign done_o        = (st_q == ST_DONE);
  assign err_unknown_o = eu_q;
  assign err_timeout_o = et_q;

  p_rsp_blocks_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_i |-> !req_valid_o);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o);

  p_tag_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (req_tag_o == $past(req_tag_o) + TAG_W'(1)));

  p_store_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_op_o) |-> (req_data_o[SC_W-1:0] != '0));

  p_trace_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid_o && $past(trc_valid_o)) |-> (trc_time_o == $past(trc_time_o) + TS_W'(1)));

endmodule

// File: tb/mtrace_gen_tb_top.sv
module mtrace_gen_tb_top;

  localparam int OPS     = 40;
  localparam int MAXO    = 4;
  localparam int TMO     = 32;
  localparam logic [31:0] SEED_A = 32'hACE1_2345;
  localparam logic [31:0] SEED_B = 32'h0BAD_F00D;

  typedef logic [72:0] req_t;   // {op, addr, data, tag}
  typedef logic [73:0] iss_t;   // {kind, tag, addr, data}

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] seed_i;
  logic [3:0]  core_id_i;
  logic        start_i;
  logic        req_valid_o, req_ready_i, req_op_o;
  logic [31:0] req_addr_o, req_data_o;
  logic [7:0]  req_tag_o;
  logic        rsp_valid_i;
  logic [7:0]  rsp_tag_i;
  logic [31:0] rsp_data_i;
  logic        trc_valid_o;
  logic [3:0]  trc_core_o;
  logic [1:0]  trc_kind_o;
  logic [7:0]  trc_tag_o;
  logic [31:0] trc_addr_o, trc_data_o, trc_time_o;
  logic        done_o, err_unknown_o, err_timeout_o;

  always #4 clk = ~clk;

  mtrace_gen #(.OPS_TOTAL(OPS), .MAX_OUT(MAXO), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .core_id_i(core_id_i), .start_i(start_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_op_o(req_op_o),
    .req_addr_o(req_addr_o), .req_data_o(req_data_o), .req_tag_o(req_tag_o),
    .rsp_valid_i(rsp_valid_i), .rsp_tag_i(rsp_tag_i), .rsp_data_i(rsp_data_i),
    .trc_valid_o(trc_valid_o), .trc_core_o(trc_core_o), .trc_kind_o(trc_kind_o),
    .trc_tag_o(trc_tag_o), .trc_addr_o(trc_addr_o), .trc_data_o(trc_data_o),
    .trc_time_o(trc_time_o), .done_o(done_o), .err_unknown_o(err_unknown_o),
    .err_timeout_o(err_timeout_o)
  );

  int          n_chk = 0, n_fail = 0;
  req_t        exp_req_q[$];
  iss_t        exp_iss_q[$];
  logic [39:0] exp_rsp_q[$];
  req_t        pend_q[$];
  logic [31:0] mem [0:3];
  bit          rsp_hold = 0, inj_req = 0;
  logic [7:0]  inj_tag = '0;
  int          fence_seen = 0;
  logic [63:0] sig = '0;
  logic [31:0] bk = '0;

  task automatic chk(input bit ok, input string rq, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected stream from the seed (R2, R3, R4, R6)
  task automatic plan_run(input logic [31:0] sd, input logic [3:0] core);
    logic [31:0] s, ad, dt;
    logic [7:0]  tg;
    logic [27:0] sc;
    s  = (sd == 32'd0) ? 32'd1 : sd;
    tg = 8'd0;
    sc = 28'd1;
    for (int i = 0; i < OPS; i++) begin
      ad = 32'h100 + {28'h0, s[3:2], 2'b00};
      if (s[1:0] == 2'b00) begin
        exp_iss_q.push_back({2'd3, tg, 32'h0, 32'h0});
      end else begin
        dt = s[1] ? {core, sc} : 32'h0;
        exp_req_q.push_back({s[1], ad, dt, tg});
        exp_iss_q.push_back({(s[1] ? 2'd1 : 2'd0), tg, ad, dt});
        tg = tg + 8'd1;
        if (s[1]) sc = sc + 28'd1;
      end
      s = s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (done_o !== 1'b1 && n < 4000) begin
      @(negedge clk);
      #2;
      n++;
    end
    chk(done_o === 1'b1, {"R9 done reached ", tag}, 80'(done_o), 80'd1);
    chk(exp_req_q.size() == 0, {"R9 all requests issued ", tag}, 80'(exp_req_q.size()), 80'd0);
    chk(pend_q.size() == 0, {"R9 none outstanding ", tag}, 80'(pend_q.size()), 80'd0);
    chk(exp_iss_q.size() == 0, {"R6 R7 all issue records ", tag}, 80'(exp_iss_q.size()), 80'd0);
    chk(exp_rsp_q.size() == 0, {"R7 all response records ", tag}, 80'(exp_rsp_q.size()), 80'd0);
  endtask

  // monitor and memory responder: pops and compares as results appear
  req_t        it, e_req, act;
  iss_t        e_iss;
  logic [39:0] e_rsp;
  int          tb_cnt = 0;
  int unsigned pi;
  logic [31:0] rd;
  bit          clash;

  initial begin : monitor
    for (int m = 0; m < 4; m++) mem[m] = 32'h0;
    req_ready_i = 1'b0;
    rsp_valid_i = 1'b0;
    rsp_tag_i   = '0;
    rsp_data_i  = '0;
    forever begin
      @(negedge clk);
      rsp_valid_i = 1'b0;
      rsp_tag_i   = '0;
      rsp_data_i  = '0;
      if (inj_req) begin
        rsp_valid_i = 1'b1;
        rsp_tag_i   = inj_tag;
        inj_req     = 0;
        exp_rsp_q.push_back({inj_tag, 32'h0});
      end else if (!rsp_hold && pend_q.size() > 0 && (tb_cnt % 3) != 1) begin
        pi = (tb_cnt % 2 == 1) ? pend_q.size() - 1 : 0;
        it = pend_q[pi];
        pend_q.delete(pi);
        if (it[72]) begin
          rd = 32'h0;
          mem[it[43:42]] = it[39:8];
        end else begin
          rd = mem[it[43:42]];
        end
        rsp_valid_i = 1'b1;
        rsp_tag_i   = it[7:0];
        rsp_data_i  = rd;
        exp_rsp_q.push_back({it[7:0], rd});
      end
      req_ready_i = ((tb_cnt % 5) != 3);
      tb_cnt++;
      #1;
      if (!rst_n) begin
        bk = '0;
      end else begin
        if (trc_valid_o) begin
          chk(trc_time_o == bk - 32'd1, "R7 record time", 80'(trc_time_o), 80'(bk - 32'd1));
          chk(trc_core_o == core_id_i, "R7 record core", 80'(trc_core_o), 80'(core_id_i));
          if (trc_kind_o == 2'd2) begin
            if (exp_rsp_q.size() == 0) begin
              chk(0, "R7 unexpected response record", 80'(trc_tag_o), 80'd0);
            end else begin
              e_rsp = exp_rsp_q.pop_front();
              chk({trc_tag_o, trc_data_o} == e_rsp, "R7 response record",
                  80'({trc_tag_o, trc_data_o}), 80'(e_rsp));
              chk(trc_addr_o == 32'h0, "R7 response address", 80'(trc_addr_o), 80'd0);
            end
          end else begin
            if (exp_iss_q.size() == 0) begin
              chk(0, "R7 unexpected issue record", 80'(trc_kind_o), 80'd0);
            end else begin
              e_iss = exp_iss_q.pop_front();
              chk({trc_kind_o, trc_tag_o, trc_addr_o, trc_data_o} == e_iss, "R6 R7 issue record",
                  80'({trc_kind_o, trc_tag_o, trc_addr_o, trc_data_o}), 80'(e_iss));
              if (trc_kind_o == 2'd3) begin
                fence_seen++;
                chk(pend_q.size() == 0, "R6 fence after drain", 80'(pend_q.size()), 80'd0);
              end
            end
          end
        end
        if (rsp_valid_i)
          chk(!req_valid_o, "R8 response holds issue", 80'(req_valid_o), 80'd0);
        if (req_valid_o && req_ready_i) begin
          act = {req_op_o, req_addr_o, req_data_o, req_tag_o};
          if (exp_req_q.size() == 0) begin
            chk(0, "R2 unexpected request", 80'(act), 80'd0);
          end else begin
            e_req = exp_req_q.pop_front();
            chk(act == e_req, "R2 R3 R4 request", 80'(act), 80'(e_req));
          end
          clash = 0;
          foreach (pend_q[k]) if (pend_q[k][1:0] == req_tag_o[1:0]) clash = 1;
          chk(!clash && pend_q.size() < MAXO, "R5 slot free at issue",
              80'(pend_q.size()), 80'(MAXO - 1));
          pend_q.push_back(act);
          sig = {sig[62:0], sig[63]} ^ 64'(act);
        end
        bk = bk + 32'd1;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  logic [63:0] sig_a;
  int          fence_a;

  initial begin : main
    rst_n     = 1'b0;
    start_i   = 1'b0;
    seed_i    = '0;
    core_id_i = 4'd1;
    repeat (3) @(negedge clk);
    #1;
    chk(req_valid_o == 0, "R1 reset request", 80'(req_valid_o), 80'd0);
    chk(trc_valid_o == 0, "R1 reset trace", 80'(trc_valid_o), 80'd0);
    chk(done_o == 0, "R1 reset done", 80'(done_o), 80'd0);
    chk(err_unknown_o == 0 && err_timeout_o == 0, "R1 reset errors",
        80'({err_unknown_o, err_timeout_o}), 80'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // run A, with a start pulse in the middle that must be ignored (R13)
    seed_i = SEED_A;
    plan_run(SEED_A, 4'd1);
    sig = '0;
    pulse_start();
    repeat (12) @(negedge clk);
    seed_i = 32'h0000_0777;
    pulse_start();
    seed_i = SEED_A;
    wait_done("R13 run A");
    sig_a   = sig;
    fence_a = fence_seen;
    chk(fence_a > 0, "R6 fences occurred", 80'(fence_a), 80'd1);
    chk(err_unknown_o == 0 && err_timeout_o == 0, "R10 R11 clean run",
        80'({err_unknown_o, err_timeout_o}), 80'd0);
    repeat (5) @(negedge clk);
    #2;
    chk(done_o == 1 && req_valid_o == 0, "R9 done holds quiet",
        80'({done_o, req_valid_o}), 80'h2);

    // run B: other seed and core
    core_id_i = 4'd2;
    seed_i    = SEED_B;
    plan_run(SEED_B, 4'd2);
    pulse_start();
    #2;
    chk(done_o == 0, "R9 done falls at start", 80'(done_o), 80'd0);
    wait_done("R4 run B");

    // run C repeats run A
    core_id_i = 4'd1;
    seed_i    = SEED_A;
    plan_run(SEED_A, 4'd1);
    sig = '0;
    pulse_start();
    wait_done("R12 run C");
    chk(sig == sig_a, "R12 same seed same stream", 80'(sig), 80'(sig_a));

    // run D: zero seed behaves as seed 1
    seed_i = 32'h0;
    plan_run(32'h0, 4'd1);
    pulse_start();
    wait_done("R2 zero seed");

    // run T: responses withheld
    seed_i   = SEED_B;
    rsp_hold = 1;
    plan_run(SEED_B, 4'd1);
    pulse_start();
    repeat (10) @(negedge clk);
    #2;
    chk(err_timeout_o == 0, "R11 no early timeout", 80'(err_timeout_o), 80'd0);
    repeat (TMO + 10) @(negedge clk);
    #2;
    chk(err_timeout_o == 1, "R11 timeout flagged", 80'(err_timeout_o), 80'd1);
    chk(err_unknown_o == 0, "R10 no false unknown", 80'(err_unknown_o), 80'd0);
    rsp_hold = 0;
    wait_done("R11 run T");
    chk(err_timeout_o == 1, "R11 timeout sticky", 80'(err_timeout_o), 80'd1);

    // foreign tag after the run
    @(negedge clk);
    inj_tag = 8'hEE;
    inj_req = 1;
    repeat (3) @(negedge clk);
    #2;
    chk(err_unknown_o == 1, "R10 unknown tag flagged", 80'(err_unknown_o), 80'd1);

    // run E: flags clear at start
    seed_i = SEED_A;
    plan_run(SEED_A, 4'd1);
    pulse_start();
    #2;
    chk(err_unknown_o == 0 && err_timeout_o == 0, "R10 R11 cleared at start",
        80'({err_unknown_o, err_timeout_o}), 80'd0);
    wait_done("R10 run E");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule